// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides how deeply a small microcontroller sleeps and turns its clocks, regulators and flash power state on and off to match. The CPU signals a wait-for-interrupt with a one-cycle pulse. The sequencer then reads a two-bit depth field and moves to one of three sleep depths, or stays awake. While it sleeps, it decides which interrupts are allowed to wake it. It also lets peripherals keep bus and generic clocks running for their own work, which is called sleepwalking.

The three depths differ in what stays powered. The lightest depth only stops the CPU clock and the bus clocks. The middle depth stops the main clock and puts the main regulator in low-power mode. It may only be entered once the low-power reference reports ready. The deepest depth turns everything off, and only an external reset brings the chip back.

Leaving the middle depth takes three steps, and each step waits for a ready input before the next one starts. First the regulator goes back to full power. Then the main clock starts. Last, the CPU and bus clocks are enabled.

Top module: `slp_ctrl`

## Requirements
- R1: After reset the block is awake: the CPU, bus and main clocks are enabled, `vreg_on`=1, `vreg_lp`=0, and `nvm_state`=2'b00. The `nvm_state` encoding is 2'b00 active, 2'b01 ultra-low-power, 2'b10 off.
- R2: `sleep_cfg` uses this encoding: 2'b00 stay awake, 2'b01 idle, 2'b10 standby, 2'b11 off. Sleep begins only on the clock edge that samples `wfi_pulse`=1. A pulse while `sleep_cfg`=2'b00 is ignored, and changing `sleep_cfg` on its own has no effect.
- R3: In idle the CPU clock is off and the main clock is on. `bus_clk_en` equals the OR of `periph_clkreq`. `gclk_en` follows `gclk_req`, `osc_en` follows `osc_req`, and `pllreg_on` follows `pllreg_en`. The regulator stays at full power and `nvm_state`=2'b00.
- R4: Idle returns to awake on the next edge if any bit of `sync_irq` is set or if `async_irq` is set.
- R5: In standby the CPU and main clocks are off. `bus_clk_en` is the OR of `periph_clkreq`. `gclk_en` equals `gclk_req` while any clock request is active and is 0 otherwise. `vreg_lp`=1 and `nvm_state`=2'b01.
- R6: In standby, bit i of `osc_en` equals `osc_req[i] | osc_runstdby[i]`.
- R7: In standby, `pllreg_on` = `pllreg_en & (pllreg_runstdby | any periph_clkreq)`.
- R8: Standby is left on `async_irq`, or on `sync_irq[i]` only when `periph_runstdby[i]`=1.
- R9: Wake from standby happens in order. First the regulator returns to full power (`vreg_lp`=0, `nvm_state`=2'b00) and the block waits for `vreg_full_rdy`. Next `mclk_en`=1 and the block waits for `mclk_rdy`. Only after that do the CPU and bus clocks come on.
- R10: A standby request made while `ref_rdy`=0 holds the block in the idle state with idle outputs. When `ref_rdy` rises, the block enters standby. An idle wake event during this wait cancels the request and returns the block to awake.
- R11: In off every enable is 0, `vreg_on`=0 and `nvm_state`=2'b10. No interrupt leaves this state, and `ext_rst` returns the block to awake.
- R12: If a wake event (any `sync_irq` bit or `async_irq`) comes in the same cycle as `wfi_pulse`, sleep entry is aborted and the block stays awake.
- R13: While awake, `gclk_en` follows `gclk_req`, `osc_en` follows `osc_req`, and `pllreg_on` follows `pllreg_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wfi_pulse | input | 1 | Wait-for-interrupt pulse from the CPU |
| sleep_cfg | input | 2 | Sleep depth selection |
| ext_rst | input | 1 | External reset request; returns the block to awake from any state |
| ref_rdy | input | 1 | Low-power reference ready |
| sync_irq | input | NPERIPH | Per-peripheral bus-clocked interrupts |
| async_irq | input | 1 | OR of asynchronous interrupt sources |
| periph_runstdby | input | NPERIPH | Peripheral is configured to run in standby |
| periph_clkreq | input | NPERIPH | Peripheral clock request while asleep |
| gclk_req | input | NGCLK | On-demand generic clock requests |
| osc_req | input | NOSC | Oscillator requests |
| osc_runstdby | input | NOSC | Oscillator stays on in standby |
| pllreg_en | input | 1 | PLL regulator enabled |
| pllreg_runstdby | input | 1 | PLL regulator stays on in standby |
| vreg_full_rdy | input | 1 | Main regulator back at full power |
| mclk_rdy | input | 1 | Main clock stable |
| cpu_clk_en | output | 1 | CPU clock enable |
| bus_clk_en | output | 1 | Bus clock enable |
| gclk_en | output | NGCLK | Generic clock enables |
| mclk_en | output | 1 | Main clock enable |
| osc_en | output | NOSC | Oscillator enables |
| pllreg_on | output | 1 | PLL regulator enable |
| vreg_lp | output | 1 | Main regulator low-power select |
| vreg_on | output | 1 | Main regulator on |
| nvm_state | output | 2 | Flash power state |

## Verification
The bench tries each wake source against each depth. A design that ignored the run-in-standby qualifier would wake from standby on a peripheral that is not allowed to wake it. A design that treated off like idle would let an interrupt wake it up. The bench raises a wake in the same cycle as the pulse, where a design with the wrong priority would fall asleep. It holds each ready input low during the standby wake to catch a design that skips a step or runs steps out of order. It also lowers `ref_rdy` to catch a design that enters standby early or that loses the cancellation when an idle wake arrives. The oscillator, PLL regulator and sleepwalking enables are swept through every combination in each state.

// File: rtl/slp_pkg.sv
package slp_pkg;

    typedef enum logic [2:0] {
        ST_ACT    = 3'd0,
        ST_IDLE   = 3'd1,
        ST_SBWAIT = 3'd2,
        ST_STBY   = 3'd3,
        ST_WREG   = 3'd4,
        ST_WMCLK  = 3'd5,
        ST_OFF    = 3'd6
    } slp_state_e;

    localparam logic [1:0] CFG_ACT  = 2'b00;
    localparam logic [1:0] CFG_IDLE = 2'b01;
    localparam logic [1:0] CFG_STBY = 2'b10;
    localparam logic [1:0] CFG_OFF  = 2'b11;

    localparam logic [1:0] NVM_ON  = 2'b00;
    localparam logic [1:0] NVM_ULP = 2'b01;
    localparam logic [1:0] NVM_OFF = 2'b10;

    typedef struct packed {
        slp_state_e state;
    } seq_reg_t;

endpackage

// File: rtl/slp_wake_qual.sv
module slp_wake_qual #(
    parameter int NPERIPH = 4
) (
    input  logic [NPERIPH-1:0] sync_irq_i,
    input  logic               async_irq_i,
    input  logic [NPERIPH-1:0] runstdby_i,
    input  logic [NPERIPH-1:0] clkreq_i,
    output logic               wake_light_o,
    output logic               wake_deep_o,
    output logic               sleepwalk_o
);
    logic [NPERIPH-1:0] deep_src;

    for (genvar i = 0; i < NPERIPH; i++) begin : g_src
        assign deep_src[i] = sync_irq_i[i] & runstdby_i[i];
    end

    always_comb begin
        wake_light_o = async_irq_i | (|sync_irq_i);
        wake_deep_o  = async_irq_i | (|deep_src);
        sleepwalk_o  = |clkreq_i;
    end
endmodule

// File: rtl/slp_seq.sv
module slp_seq
    import slp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wfi_i,
    input  logic [1:0] cfg_i,
    input  logic       ext_rst_i,
    input  logic       ref_rdy_i,
    input  logic       wake_light_i,
    input  logic       wake_deep_i,
    input  logic       vreg_rdy_i,
    input  logic       mclk_rdy_i,
    output slp_state_e state_o
);
    seq_reg_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        case (seq_q.state)
            ST_ACT: begin
                if (wfi_i && !wake_light_i) begin
                    case (cfg_i)
                        CFG_IDLE: seq_d.state = ST_IDLE;
                        CFG_STBY: seq_d.state = ref_rdy_i ? ST_STBY : ST_SBWAIT;
                        CFG_OFF:  seq_d.state = ST_OFF;
                        default:  seq_d.state = ST_ACT;
                    endcase
                end
            end
            ST_IDLE: begin
                if (wake_light_i) seq_d.state = ST_ACT;
            end
            ST_SBWAIT: begin
                if (wake_light_i)   seq_d.state = ST_ACT;
                else if (ref_rdy_i) seq_d.state = ST_STBY;
            end
            ST_STBY: begin
                if (wake_deep_i) seq_d.state = ST_WREG;
            end
            ST_WREG: begin
                if (vreg_rdy_i) seq_d.state = ST_WMCLK;
            end
            ST_WMCLK: begin
                if (mclk_rdy_i) seq_d.state = ST_ACT;
            end
            ST_OFF: seq_d.state = ST_OFF;
            default: seq_d.state = ST_ACT;
        endcase
        if (ext_rst_i) seq_d.state = ST_ACT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{state: ST_ACT};
        else        seq_q <= seq_d;
    end

    assign state_o = seq_q.state;
endmodule

// File: rtl/slp_gate.sv
module slp_gate
    import slp_pkg::*;
#(
    parameter int NGCLK = 4,
    parameter int NOSC  = 2
) (
    input  slp_state_e       state_i,
    input  logic             sleepwalk_i,
    input  logic [NGCLK-1:0] gclk_req_i,
    input  logic [NOSC-1:0]  osc_req_i,
    input  logic [NOSC-1:0]  osc_rs_i,
    input  logic             pll_en_i,
    input  logic             pll_rs_i,
    output logic             cpu_clk_en_o,
    output logic             bus_clk_en_o,
    output logic [NGCLK-1:0] gclk_en_o,
    output logic             mclk_en_o,
    output logic [NOSC-1:0]  osc_en_o,
    output logic             pllreg_on_o,
    output logic             vreg_lp_o,
    output logic             vreg_on_o,
    output logic [1:0]       nvm_state_o
);
    logic deep;
    logic off;
    logic [NOSC-1:0] osc_deep;

    assign deep = (state_i == ST_STBY) || (state_i == ST_WREG) || (state_i == ST_WMCLK);
    assign off  = (state_i == ST_OFF);

    for (genvar i = 0; i < NOSC; i++) begin : g_osc
        assign osc_deep[i] = osc_req_i[i] | osc_rs_i[i];
        assign osc_en_o[i] = off  ? 1'b0 :
                             deep ? osc_deep[i] : osc_req_i[i];
    end

    always_comb begin
        cpu_clk_en_o = (state_i == ST_ACT);
        bus_clk_en_o = (state_i == ST_ACT) || (!off && sleepwalk_i);
        mclk_en_o    = (state_i == ST_ACT) || (state_i == ST_IDLE) ||
                       (state_i == ST_SBWAIT) || (state_i == ST_WMCLK);
        if (off)
            gclk_en_o = '0;
        else if (deep)
            gclk_en_o = sleepwalk_i ? gclk_req_i : '0;
        else
            gclk_en_o = gclk_req_i;
        if (off)
            pllreg_on_o = 1'b0;
        else if (deep)
            pllreg_on_o = pll_en_i & (pll_rs_i | sleepwalk_i);
        else
            pllreg_on_o = pll_en_i;
        vreg_lp_o = (state_i == ST_STBY);
        vreg_on_o = !off;
        if (off)                     nvm_state_o = NVM_OFF;
        else if (state_i == ST_STBY) nvm_state_o = NVM_ULP;
        else                         nvm_state_o = NVM_ON;
    end
endmodule

// File: rtl/slp_ctrl.sv
module slp_ctrl
    import slp_pkg::*;
#(
    parameter int NPERIPH = 4,
    parameter int NGCLK   = 4,
    parameter int NOSC    = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wfi_pulse,
    input  logic [1:0]         sleep_cfg,
    input  logic               ext_rst,
    input  logic               ref_rdy,
    input  logic [NPERIPH-1:0] sync_irq,
    input  logic               async_irq,
    input  logic [NPERIPH-1:0] periph_runstdby,
    input  logic [NPERIPH-1:0] periph_clkreq,
    input  logic [NGCLK-1:0]   gclk_req,
    input  logic [NOSC-1:0]    osc_req,
    input  logic [NOSC-1:0]    osc_runstdby,
    input  logic               pllreg_en,
    input  logic               pllreg_runstdby,
    input  logic               vreg_full_rdy,
    input  logic               mclk_rdy,
    output logic               cpu_clk_en,
    output logic               bus_clk_en,
    output logic [NGCLK-1:0]   gclk_en,
    output logic               mclk_en,
    output logic [NOSC-1:0]    osc_en,
    output logic               pllreg_on,
    output logic               vreg_lp,
    output logic               vreg_on,
    output logic [1:0]         nvm_state
);
    logic       wake_light;
    logic       wake_deep;
    logic       sleepwalk;
    slp_state_e state;

    slp_wake_qual #(.NPERIPH(NPERIPH)) u_wake (
        .sync_irq_i   (sync_irq),
        .async_irq_i  (async_irq),
        .runstdby_i   (periph_runstdby),
        .clkreq_i     (periph_clkreq),
        .wake_light_o (wake_light),
        .wake_deep_o  (wake_deep),
        .sleepwalk_o  (sleepwalk)
    );

    slp_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .wfi_i        (wfi_pulse),
        .cfg_i        (sleep_cfg),
        .ext_rst_i    (ext_rst),
        .ref_rdy_i    (ref_rdy),
        .wake_light_i (wake_light),
        .wake_deep_i  (wake_deep),
        .vreg_rdy_i   (vreg_full_rdy),
        .mclk_rdy_i   (mclk_rdy),
        .state_o      (state)
    );

    slp_gate #(.NGCLK(NGCLK), .NOSC(NOSC)) u_gate (
        .state_i      (state),
        .sleepwalk_i  (sleepwalk),
        .gclk_req_i   (gclk_req),
        .osc_req_i    (osc_req),
        .osc_rs_i     (osc_runstdby),
        .pll_en_i     (pllreg_en),
        .pll_rs_i     (pllreg_runstdby),
        .cpu_clk_en_o (cpu_clk_en),
        .bus_clk_en_o (bus_clk_en),
        .gclk_en_o    (gclk_en),
        .mclk_en_o    (mclk_en),
        .osc_en_o     (osc_en),
        .pllreg_on_o  (pllreg_on),
        .vreg_lp_o    (vreg_lp),
        .vreg_on_o    (vreg_on),
        .nvm_state_o  (nvm_state)
    );
endmodule

// File: rtl/slp_ctrl_chk.sv
module slp_ctrl_chk
    import slp_pkg::*;
#(
    parameter int NPERIPH = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wfi_pulse,
    input logic [1:0]         sleep_cfg,
    input logic               ext_rst,
    input logic               ref_rdy,
    input logic [NPERIPH-1:0] sync_irq,
    input logic               async_irq,
    input logic               cpu_clk_en,
    input logic               mclk_en,
    input logic               vreg_lp,
    input logic               vreg_on,
    input logic [1:0]         nvm_state
);
    logic any_wake;
    assign any_wake = async_irq | (|sync_irq);

    AST_SLEEP_NEEDS_WFI: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_clk_en) |-> $past(wfi_pulse)); // R2

    AST_AWAKE_CFG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_en && wfi_pulse && sleep_cfg == CFG_ACT) |=> cpu_clk_en); // R2

    AST_ENTRY_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_en && wfi_pulse && any_wake) |=> cpu_clk_en); // R12

    AST_STBY_REF_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vreg_lp) |-> $past(ref_rdy)); // R10

    AST_MCLK_AFTER_REG: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mclk_en) && !$past(ext_rst)) |-> !$past(vreg_lp)); // R9

    AST_CPU_AFTER_MCLK: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cpu_clk_en) && !$past(ext_rst)) |-> $past(mclk_en)); // R9

    AST_OFF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (nvm_state == NVM_OFF && !ext_rst) |=> nvm_state == NVM_OFF); // R11

    AST_OFF_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (nvm_state == NVM_OFF) |-> (!cpu_clk_en && !mclk_en && !vreg_on)); // R11
endmodule

bind slp_ctrl slp_ctrl_chk #(.NPERIPH(NPERIPH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wfi_pulse  (wfi_pulse),
    .sleep_cfg  (sleep_cfg),
    .ext_rst    (ext_rst),
    .ref_rdy    (ref_rdy),
    .sync_irq   (sync_irq),
    .async_irq  (async_irq),
    .cpu_clk_en (cpu_clk_en),
    .mclk_en    (mclk_en),
    .vreg_lp    (vreg_lp),
    .vreg_on    (vreg_on),
    .nvm_state  (nvm_state)
);

// File: tb/slp_ctrl_test.sv
module slp_ctrl_test;
    localparam int CLK_P = 10;
    localparam int NP = 4;
    localparam int NG = 4;
    localparam int NO = 2;
    localparam int VW = 9 + NG + NO;

    localparam int M_ACT = 0, M_IDLE = 1, M_STBY = 2, M_WREG = 3, M_WMCLK = 4, M_OFF = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wfi_pulse = 1'b0;
    logic [1:0] sleep_cfg = 2'b00;
    logic ext_rst = 1'b0;
    logic ref_rdy = 1'b1;
    logic [NP-1:0] sync_irq = '0;
    logic async_irq = 1'b0;
    logic [NP-1:0] periph_runstdby = '0;
    logic [NP-1:0] periph_clkreq = '0;
    logic [NG-1:0] gclk_req = '0;
    logic [NO-1:0] osc_req = '0;
    logic [NO-1:0] osc_runstdby = '0;
    logic pllreg_en = 1'b0;
    logic pllreg_runstdby = 1'b0;
    logic vreg_full_rdy = 1'b1;
    logic mclk_rdy = 1'b1;
    logic cpu_clk_en, bus_clk_en, mclk_en, pllreg_on, vreg_lp, vreg_on;
    logic [NG-1:0] gclk_en;
    logic [NO-1:0] osc_en;
    logic [1:0] nvm_state;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    slp_ctrl #(.NPERIPH(NP), .NGCLK(NG), .NOSC(NO)) uut (.*);

    function automatic logic [VW-1:0] expect_vec(int m);
        logic sw;
        logic cpu, bus, mc, pll, vlp, von;
        logic [NG-1:0] g;
        logic [NO-1:0] o;
        logic [1:0] nv;
        sw = |periph_clkreq;
        cpu = 0; bus = sw; g = gclk_req; mc = 0; o = osc_req; pll = pllreg_en;
        vlp = 0; von = 1; nv = 2'b00;
        case (m)
            M_ACT: begin cpu = 1; bus = 1; mc = 1; end
            M_IDLE: mc = 1;
            M_STBY, M_WREG, M_WMCLK: begin
                g = sw ? gclk_req : '0;
                o = osc_req | osc_runstdby;
                pll = pllreg_en & (pllreg_runstdby | sw);
                if (m == M_STBY) begin vlp = 1; nv = 2'b01; end
                if (m == M_WMCLK) mc = 1;
            end
            default: begin
                bus = 0; g = '0; o = '0; pll = 0; von = 0; nv = 2'b10;
            end
        endcase
        return {cpu, bus, g, mc, o, pll, vlp, von, nv};
    endfunction

    task automatic chk(string rq, int m);
        logic [VW-1:0] act, exv;
        act = {cpu_clk_en, bus_clk_en, gclk_en, mclk_en, osc_en, pllreg_on, vreg_lp, vreg_on, nvm_state};
        exv = expect_vec(m);
        total++;
        if (act !== exv) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exv);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 0;
        sync_irq = '0; async_irq = 0; ext_rst = 0; wfi_pulse = 0;
        repeat (2) step();
        rst_n = 1;
        step();
    endtask

    task automatic do_wfi(logic [1:0] cfg);
        sleep_cfg = cfg;
        wfi_pulse = 1;
        step();
        wfi_pulse = 0;
    endtask

    // exit standby through both ready steps with readies held high
    task automatic finish_wake();
        vreg_full_rdy = 1; mclk_rdy = 1;
        step(); step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog R9 actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        chk("R1 reset state", M_ACT);

        // R13 awake sweep of on-demand requests
        for (int v = 0; v < (1 << (NG + NO + 1)); v++) begin
            {gclk_req, osc_req, pllreg_en} = v[NG+NO:0];
            #1 chk("R13 awake on-demand", M_ACT);
        end

        // R2 ignored pulse and cfg change without pulse
        do_wfi(2'b00);
        chk("R2 pulse with awake cfg", M_ACT);
        for (int c = 1; c < 4; c++) begin
            sleep_cfg = c[1:0];
            step();
            chk("R2 cfg without pulse", M_ACT);
        end

        // R3 / R4 idle outputs and every wake source
        for (int s = 0; s <= NP; s++) begin
            periph_runstdby = '0;
            do_wfi(2'b01);
            chk("R3 idle entry", M_IDLE);
            for (int v = 0; v < 4; v++) begin
                periph_clkreq = v[0] ? 4'b0100 : '0;
                gclk_req = v[1] ? 4'b1010 : 4'b0001;
                osc_req = v[1:0];
                #1 chk("R3 idle sweep", M_IDLE);
            end
            periph_clkreq = '0;
            step();
            chk("R4 idle holds without wake", M_IDLE);
            if (s < NP) sync_irq = NP'(1) << s; else async_irq = 1;
            step();
            sync_irq = '0; async_irq = 0;
            chk("R4 idle wake", M_ACT);
        end

        // R5 R6 R7 standby outputs
        ref_rdy = 1;
        do_wfi(2'b10);
        chk("R5 standby entry", M_STBY);
        for (int v = 0; v < 16; v++) begin
            {osc_req, osc_runstdby} = v[3:0];
            #1 chk("R6 oscillators in standby", M_STBY);
        end
        for (int v = 0; v < 8; v++) begin
            {pllreg_en, pllreg_runstdby} = v[1:0];
            periph_clkreq = v[2] ? 4'b0010 : '0;
            gclk_req = 4'b0110;
            #1 chk("R7 pll regulator in standby", M_STBY);
            chk("R5 sleepwalking clocks", M_STBY);
        end
        periph_clkreq = '0;
        async_irq = 1; step(); async_irq = 0;
        chk("R8 async wakes standby", M_WREG);
        finish_wake();
        chk("R9 awake after sequence", M_ACT);

        // R8 qualification per peripheral
        for (int p = 0; p < NP; p++) begin
            do_wfi(2'b10);
            periph_runstdby = ~(NP'(1) << p);
            sync_irq = NP'(1) << p;
            step(); step();
            chk("R8 unqualified sync ignored", M_STBY);
            periph_runstdby = NP'(1) << p;
            step();
            sync_irq = '0;
            chk("R8 qualified sync wakes", M_WREG);
            finish_wake();
            chk("R8 back awake", M_ACT);
        end

        // R9 ordered steps held by readies
        vreg_full_rdy = 0; mclk_rdy = 0;
        do_wfi(2'b10);
        async_irq = 1; step(); async_irq = 0;
        repeat (3) step();
        chk("R9 waiting regulator", M_WREG);
        vreg_full_rdy = 1; step(); vreg_full_rdy = 0;
        repeat (3) step();
        chk("R9 waiting main clock", M_WMCLK);
        mclk_rdy = 1; step();
        chk("R9 cpu clocks last", M_ACT);

        // R10 reference gate
        ref_rdy = 0;
        do_wfi(2'b10);
        repeat (3) step();
        chk("R10 waits in idle", M_IDLE);
        ref_rdy = 1; step();
        chk("R10 enters standby on ready", M_STBY);
        async_irq = 1; step(); async_irq = 0;
        finish_wake();
        ref_rdy = 0;
        do_wfi(2'b10);
        sync_irq = 4'b1000; step(); sync_irq = '0;
        chk("R10 idle wake cancels", M_ACT);
        ref_rdy = 1; step(); step();
        chk("R10 cancel persists", M_ACT);

        // R11 off
        do_wfi(2'b11);
        chk("R11 off entry", M_OFF);
        async_irq = 1; sync_irq = '1; periph_runstdby = '1;
        step(); step();
        chk("R11 interrupts ignored in off", M_OFF);
        async_irq = 0; sync_irq = '0;
        ext_rst = 1; step(); ext_rst = 0;
        chk("R11 external reset exits", M_ACT);

        // R12 abort for every depth and both wake kinds
        for (int c = 1; c < 4; c++) begin
            for (int k = 0; k < 2; k++) begin
                if (k == 0) async_irq = 1; else sync_irq = 4'b0001;
                do_wfi(c[1:0]);
                async_irq = 0; sync_irq = '0;
                chk("R12 abort on coincident wake", M_ACT);
            end
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule